// File: doc/BRIEF.md
# Load-Store Ordering Queue

This block keeps the memory operations of an out-of-order core in program order and decides when each load may go to the data cache. Operations are allocated at the tail in program order. Each slot later receives its effective address as a single event from address generation. A store also receives its data as a separate event, and that event never holds back the address. The head slot retires on a commit pulse. A store reaches the cache only then, because an older instruction could still fault.

A mode input selects between two ways of handling loads. In the cautious mode a load does not issue while any older store still has an unknown address. In the speculative mode a load issues as soon as its own address is known. If an older store later resolves to the same address, the queue reports the conflict and the load issues again. In both modes a load whose address matches an older resolved store takes the data of the youngest such store instead of reading the cache. A flush drops every slot younger than a given slot.

Top module: `lsq_core`

## Requirements
- R1: After reset the queue is empty: `alloc_ready`=1, `alloc_idx`=0, and `ld_req_valid`, `st_wr_valid` and `replay_valid` are 0.
- R2: Allocations take successive slots 0,1,2,… wrapping modulo DEPTH, reported on `alloc_idx`. With DEPTH slots held, `alloc_ready` is 0 and an `alloc_valid` pulse changes nothing.
- R3: A load with no older store in the queue raises `ld_req_valid` with its slot and address in the cycle after its address event. It requests once only.
- R4: With `pred_en`=0, a load does not request while any older store has an unknown address. It requests in the cycle after the last such store address arrives.
- R5: With `pred_en`=1, a load requests in the cycle after its address event even if older store addresses are unknown. When an older store's address later arrives and equals the load's address, `replay_valid`=1 with `replay_idx` = the load slot in the next cycle, and the load requests again.
- R6: A store is written only at commit. In the cycle after `commit_valid` retires a head store, `st_wr_valid`=1 with that store's address and data. At no other time is `st_wr_valid` 1.
- R7: When older stores with known addresses match a load's address, the load uses the youngest of them. If that store has data, the request carries `ld_req_fwd`=1 and its data. If it has no data, the load waits and requests in the cycle after the data arrives.
- R8: A load whose address differs from every older resolved store may request ahead of older loads. A store resolving to a different address causes no replay.
- R9: `flush_valid` with `flush_idx` = k keeps slot k and older slots and drops all younger ones. The next allocation gets slot k+1, and DEPTH minus (kept count) slots are then free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_en | input | 1 | 1 = speculative loads with replay, 0 = wait for older store addresses |
| alloc_valid | input | 1 | Allocate one slot at the tail |
| alloc_store | input | 1 | Allocated operation is a store (1) or a load (0) |
| alloc_ready | output | 1 | A slot is free |
| alloc_idx | output | IW | Slot that the next allocation takes |
| agu_valid | input | 1 | Effective address event |
| agu_idx | input | IW | Slot receiving the address |
| agu_addr | input | AW | Effective address |
| sdata_valid | input | 1 | Store data event |
| sdata_idx | input | IW | Store slot receiving data |
| sdata_val | input | DW | Store data |
| commit_valid | input | 1 | Retire the head slot |
| flush_valid | input | 1 | Drop slots younger than `flush_idx` |
| flush_idx | input | IW | Youngest slot kept by a flush |
| ld_req_valid | output | 1 | Load access request this cycle |
| ld_req_idx | output | IW | Slot of the requesting load |
| ld_req_addr | output | AW | Load address |
| ld_req_fwd | output | 1 | Data is supplied from an older store |
| ld_req_fwd_data | output | DW | Forwarded store data |
| replay_valid | output | 1 | A load must be re-executed |
| replay_idx | output | IW | Slot of the re-executed load |
| st_wr_valid | output | 1 | Committed store write |
| st_wr_addr | output | AW | Store address |
| st_wr_data | output | DW | Store data |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. A load request follows its own address event or the last blocking store address or data event. A replay follows the conflicting store address. A cache write follows the commit pulse. The bench drives each event just after a falling edge and samples the outputs at the next falling edge, which is one registered update later. It then checks that the request has gone in the following cycle. The mode, address-match and early-data choices are swept over all eight combinations, and in each case the bench works out from the requirements which of request, forward and replay are due and when.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
   typedef struct packed {
      logic vld;    // slot holds an operation
      logic st;     // 1 = store
      logic a_ok;   // address known
      logic d_ok;   // store data known
      logic done;   // load has been sent to memory
   } slot_flags_t;
endpackage

// File: rtl/lsq_dep_check.sv
module lsq_dep_check
   import lsq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 16,
   parameter int DW    = 16,
   parameter int SELF  = 0,
   localparam int IW   = $clog2(DEPTH)
) (
   input  slot_flags_t      fl  [DEPTH],
   input  logic [AW-1:0]    ad  [DEPTH],
   input  logic [DW-1:0]    dt  [DEPTH],
   input  logic [IW-1:0]    rel [DEPTH],
   input  logic             pred_en,
   output logic             go,
   output logic             fwd,
   output logic [DW-1:0]    fwd_data
);
   logic          unknown;
   logic          hit;
   logic          hit_dok;
   logic [IW-1:0] hit_rel;

   always_comb begin
      unknown  = 1'b0;
      hit      = 1'b0;
      hit_dok  = 1'b0;
      hit_rel  = '0;
      fwd_data = '0;
      for (int j = 0; j < DEPTH; j++) begin
         if (j != SELF && fl[j].vld && fl[j].st && rel[j] < rel[SELF]) begin
            if (!fl[j].a_ok)
               unknown = 1'b1;
            else if (ad[j] == ad[SELF] && (!hit || rel[j] > hit_rel)) begin
               hit      = 1'b1;
               hit_rel  = rel[j];
               hit_dok  = fl[j].d_ok;
               fwd_data = dt[j];
            end
         end
      end
      go  = fl[SELF].vld && !fl[SELF].st && fl[SELF].a_ok && !fl[SELF].done
            && (pred_en || !unknown) && (!hit || hit_dok);
      fwd = hit;
   end
endmodule

// File: rtl/lsq_oldest_pick.sv
module lsq_oldest_pick #(
   parameter int DEPTH = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] req,
   input  logic [IW-1:0]    rel [DEPTH],
   output logic             found,
   output logic [IW-1:0]    idx
);
   logic [IW-1:0] best;

   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (req[i] && (!found || rel[i] < best)) begin
            found = 1'b1;
            best  = rel[i];
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/lsq_core.sv
module lsq_core
   import lsq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 16,
   parameter int DW    = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pred_en,
   input  logic          alloc_valid,
   input  logic          alloc_store,
   output logic          alloc_ready,
   output logic [IW-1:0] alloc_idx,
   input  logic          agu_valid,
   input  logic [IW-1:0] agu_idx,
   input  logic [AW-1:0] agu_addr,
   input  logic          sdata_valid,
   input  logic [IW-1:0] sdata_idx,
   input  logic [DW-1:0] sdata_val,
   input  logic          commit_valid,
   input  logic          flush_valid,
   input  logic [IW-1:0] flush_idx,
   output logic          ld_req_valid,
   output logic [IW-1:0] ld_req_idx,
   output logic [AW-1:0] ld_req_addr,
   output logic          ld_req_fwd,
   output logic [DW-1:0] ld_req_fwd_data,
   output logic          replay_valid,
   output logic [IW-1:0] replay_idx,
   output logic          st_wr_valid,
   output logic [AW-1:0] st_wr_addr,
   output logic [DW-1:0] st_wr_data
);
   localparam logic [IW:0] FULL = (IW+1)'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("lsq_core: DEPTH must be a power of two and at least 2");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("lsq_core: AW and DW must be positive");
      end
   endgenerate

   slot_flags_t   fl_q [DEPTH];
   logic [AW-1:0] ad_q [DEPTH];
   logic [DW-1:0] dt_q [DEPTH];
   logic [IW-1:0] head_q, tail_q;
   logic [IW:0]   cnt_q;

   logic [IW-1:0]    rel [DEPTH];
   logic [DEPTH-1:0] go, fwd, squash;
   logic [DW-1:0]    fd  [DEPTH];
   logic             sq_any;
   logic [IW-1:0]    sq_idx;
   logic             acc, pop;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) rel[i] = IW'(i) - head_q;
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         lsq_dep_check #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SELF(g)) u_dep (
            .fl(fl_q), .ad(ad_q), .dt(dt_q), .rel(rel), .pred_en(pred_en),
            .go(go[g]), .fwd(fwd[g]), .fwd_data(fd[g]));
      end
   endgenerate

   lsq_oldest_pick #(.DEPTH(DEPTH)) u_ld_pick (
      .req(go), .rel(rel), .found(ld_req_valid), .idx(ld_req_idx));

   assign ld_req_addr     = ad_q[ld_req_idx];
   assign ld_req_fwd      = ld_req_valid && fwd[ld_req_idx];
   assign ld_req_fwd_data = fd[ld_req_idx];

   // loads already sent (or being sent now) that a resolving older store hits
   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         squash[j] = agu_valid && fl_q[agu_idx].vld && fl_q[agu_idx].st
                     && fl_q[j].vld && !fl_q[j].st && fl_q[j].a_ok
                     && (fl_q[j].done || (ld_req_valid && ld_req_idx == IW'(j)))
                     && rel[j] > rel[agu_idx] && ad_q[j] == agu_addr;
      end
   end

   lsq_oldest_pick #(.DEPTH(DEPTH)) u_sq_pick (
      .req(squash), .rel(rel), .found(sq_any), .idx(sq_idx));

   assign alloc_ready = (cnt_q != FULL);
   assign alloc_idx   = tail_q;
   assign acc         = alloc_valid && alloc_ready;
   assign pop         = commit_valid && (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < DEPTH; j++) begin
            fl_q[j] <= '0;
            ad_q[j] <= '0;
            dt_q[j] <= '0;
         end
         head_q       <= '0;
         tail_q       <= '0;
         cnt_q        <= '0;
         st_wr_valid  <= 1'b0;
         st_wr_addr   <= '0;
         st_wr_data   <= '0;
         replay_valid <= 1'b0;
         replay_idx   <= '0;
      end else begin
         st_wr_valid  <= 1'b0;
         replay_valid <= sq_any;
         replay_idx   <= sq_idx;
         if (ld_req_valid) fl_q[ld_req_idx].done <= 1'b1;
         if (agu_valid) begin
            fl_q[agu_idx].a_ok <= 1'b1;
            ad_q[agu_idx]      <= agu_addr;
         end
         if (sdata_valid) begin
            fl_q[sdata_idx].d_ok <= 1'b1;
            dt_q[sdata_idx]      <= sdata_val;
         end
         for (int j = 0; j < DEPTH; j++)
            if (squash[j]) fl_q[j].done <= 1'b0;
         if (flush_valid) begin
            for (int j = 0; j < DEPTH; j++)
               if (rel[j] > rel[flush_idx]) fl_q[j].vld <= 1'b0;
            tail_q <= flush_idx + IW'(1);
            cnt_q  <= {1'b0, rel[flush_idx]} + (IW+1)'(1);
         end else begin
            if (pop) begin
               fl_q[head_q].vld <= 1'b0;
               head_q           <= head_q + IW'(1);
               if (fl_q[head_q].st) begin
                  st_wr_valid <= 1'b1;
                  st_wr_addr  <= ad_q[head_q];
                  st_wr_data  <= dt_q[head_q];
               end
            end
            if (acc) begin
               fl_q[tail_q] <= '{vld: 1'b1, st: alloc_store, default: 1'b0};
               tail_q       <= tail_q + IW'(1);
            end
            cnt_q <= cnt_q + (IW+1)'(acc) - (IW+1)'(pop);
         end
      end
   end

   AST_NO_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> !ld_req_valid);                                        // R1
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && !alloc_ready && !flush_valid && !commit_valid) |=> $stable(cnt_q)); // R2
   AST_REPLAY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      replay_valid |-> $past(agu_valid));                                      // R5
   AST_WRITE_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr_valid |-> $past(commit_valid));                                    // R6
   AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> (alloc_idx == $past(flush_idx) + IW'(1)));               // R9
endmodule

// File: tb/sim_lsq_core.sv
`timescale 1ns/1ps
module sim_lsq_core;
   localparam int DEPTH = 16;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n, pred_en;
   logic          alloc_valid, alloc_store, alloc_ready;
   logic [IW-1:0] alloc_idx;
   logic          agu_valid;
   logic [IW-1:0] agu_idx;
   logic [AW-1:0] agu_addr;
   logic          sdata_valid;
   logic [IW-1:0] sdata_idx;
   logic [DW-1:0] sdata_val;
   logic          commit_valid, flush_valid;
   logic [IW-1:0] flush_idx;
   logic          ld_req_valid, ld_req_fwd, replay_valid, st_wr_valid;
   logic [IW-1:0] ld_req_idx, replay_idx;
   logic [AW-1:0] ld_req_addr, st_wr_addr;
   logic [DW-1:0] ld_req_fwd_data, st_wr_data;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   lsq_core #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      alloc_valid  = 1'b0;
      agu_valid    = 1'b0;
      sdata_valid  = 1'b0;
      commit_valid = 1'b0;
      flush_valid  = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cyc();
      cyc();
      rst_n = 1'b1;
   endtask

   task automatic do_alloc(input logic st);
      alloc_valid = 1'b1; alloc_store = st; cyc();
   endtask

   task automatic do_agu(input int idx, input logic [AW-1:0] a);
      agu_valid = 1'b1; agu_idx = IW'(idx); agu_addr = a; cyc();
   endtask

   task automatic do_data(input int idx, input logic [DW-1:0] d);
      sdata_valid = 1'b1; sdata_idx = IW'(idx); sdata_val = d; cyc();
   endtask

   task automatic do_commit();
      commit_valid = 1'b1; cyc();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      alloc_valid = 0; alloc_store = 0; agu_valid = 0; agu_idx = 0; agu_addr = 0;
      sdata_valid = 0; sdata_idx = 0; sdata_val = 0; commit_valid = 0;
      flush_valid = 0; flush_idx = 0; pred_en = 0; rst_n = 0;
      @(negedge clk);
      do_reset();
      chk("R1 ready", alloc_ready, 1);
      chk("R1 idx", alloc_idx, 0);
      chk("R1 ld_req", ld_req_valid, 0);
      chk("R1 st_wr", st_wr_valid, 0);
      chk("R1 replay", replay_valid, 0);

      // R2 fill, full, ignored allocation; R9 flush and refill
      for (int i = 0; i < DEPTH; i++) begin
         chk("R2 slot order", alloc_idx, i);
         do_alloc(i == 5);
      end
      chk("R2 full", alloc_ready, 0);
      do_alloc(1'b0);
      chk("R2 ignored when full", alloc_ready, 0);
      flush_valid = 1'b1; flush_idx = 4'd3; cyc();
      chk("R9 ready after flush", alloc_ready, 1);
      chk("R9 next slot", alloc_idx, 4);
      for (int i = 0; i < DEPTH - 4; i++) do_alloc(1'b0);
      chk("R9 freed count", alloc_ready, 0);
      chk("R9 wrap", alloc_idx, 0);

      // R3 lone load
      do_reset();
      do_alloc(1'b0);
      do_agu(0, 16'h0011);
      chk("R3 req", ld_req_valid, 1);
      chk("R3 addr", ld_req_addr, 16'h0011);
      chk("R3 fwd", ld_req_fwd, 0);
      cyc();
      chk("R3 single request", ld_req_valid, 0);

      // R8 younger load ahead of older load
      do_reset();
      do_alloc(1'b0);
      do_alloc(1'b0);
      do_agu(1, 16'h0022);
      chk("R8 young load req", ld_req_valid, 1);
      chk("R8 young load idx", ld_req_idx, 1);

      // R7 youngest matching store supplies data
      do_reset();
      do_alloc(1'b1); do_alloc(1'b1); do_alloc(1'b0);
      do_agu(0, 16'h0060); do_data(0, 16'h1111);
      do_agu(1, 16'h0060); do_data(1, 16'h2222);
      chk("R7 no req before addr", ld_req_valid, 0);
      do_agu(2, 16'h0060);
      chk("R7 req", ld_req_valid, 1);
      chk("R7 fwd", ld_req_fwd, 1);
      chk("R7 youngest data", ld_req_fwd_data, 16'h2222);
      do_commit();
      chk("R6 first store", st_wr_data, 16'h1111);
      do_commit();
      chk("R6 second store", st_wr_data, 16'h2222);

      // R4/R5/R7/R8 sweep over mode, address match and early data
      for (int p = 0; p < 2; p++)
         for (int m = 0; m < 2; m++)
            for (int e = 0; e < 2; e++) begin
               logic [DW-1:0] val;
               logic [AW-1:0] sa;
               val = 16'hA000 | DW'(p * 4 + m * 2 + e);
               sa  = (m != 0) ? 16'h0040 : 16'h0050;
               do_reset();
               pred_en = p[0];
               do_alloc(1'b1);
               do_alloc(1'b0);
               if (e != 0) do_data(0, val);
               do_agu(1, 16'h0040);
               chk(p != 0 ? "R5 early req" : "R4 wait", ld_req_valid, p);
               if (p != 0) chk("R5 early idx", ld_req_idx, 1);
               do_agu(0, sa);
               chk(m != 0 ? "R5 replay" : "R8 no replay", replay_valid, (p != 0 && m != 0));
               if (p != 0 && m != 0) chk("R5 replay idx", replay_idx, 1);
               chk(p != 0 ? "R5 reissue" : "R4 after store addr", ld_req_valid,
                   (p != 0) ? (m != 0 && e != 0) : (m == 0 || e != 0));
               if (ld_req_valid && m != 0) begin
                  chk("R7 fwd flag", ld_req_fwd, 1);
                  chk("R7 fwd data", ld_req_fwd_data, val);
               end
               if (ld_req_valid && m == 0) chk("R8 plain read", ld_req_fwd, 0);
               chk("R6 no early write", st_wr_valid, 0);
               if (e == 0) begin
                  do_data(0, val);
                  chk("R7 req after data", ld_req_valid, m);
                  if (m != 0) chk("R7 late fwd data", ld_req_fwd_data, val);
               end
               do_commit();
               chk("R6 write", st_wr_valid, 1);
               chk("R6 addr", st_wr_addr, sa);
               chk("R6 data", st_wr_data, val);
               do_commit();
               chk("R6 load commit no write", st_wr_valid, 0);
            end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule